// File: doc/BRIEF.md
# Multi-channel shadowed PWM controller

This block is a register-mapped pulse-width generator with six channels that run on their own. Each channel has a control word, a period word and a duty word, all 32 bits wide and counted in clock cycles. Each channel drives one output pin. Software writes the period, the duty and the polarity into staging copies. Setting the update bit in the control word asks for these copies to be taken over. On an idle channel the takeover happens at once. On a running channel it waits until the current period ends, so a waveform is never cut short or stretched in the middle.

A channel starts with a separate control write that carries the start bit, after its period and duty have been committed. It then counts from 0 to period−1 and wraps, repeating forever. The output is in its active phase while the count is below the committed duty value. The polarity bit picks whether that active phase is high or low. To switch a channel off, software writes a duty of zero, which gives a constant low output. A period of zero also keeps the output low.

The bus is a simple single-cycle register port. Writes take effect at the clock edge where they are presented. Read data is registered and appears after that same edge.

Top module: `pwm_bank`

## Requirements
- R1: After reset every register of every channel reads as zero and every output is low.
- R2: Channel c occupies addresses c×0x20 up to c×0x20+0x1F. Its control word is at offset 0x00, its period at 0x08 and its duty at 0x0C. Reads of the period and duty words return the value last written by software, whether or not that value has been committed. Read data is valid after the edge that samples the read.
- R3: An access to any other offset, or to a channel index of 6 or above, reads as zero and changes no register.
- R4: Control word bits: bit 0 = start, bit 2 = update, bit 5 = continuous, bit 8 = polarity. Reading the control word returns bit 0 = channel running, bit 2 = update pending, and bits 5 and 8 as last written. Once set, running stays set until reset.
- R5: Writes to period, duty or polarity without the update bit leave the output waveform unchanged.
- R6: When an update is requested on an idle channel, the staged values are committed at the next edge. The control word then reads bit 2 as 0 from two edges after the write.
- R7: When an update is requested on a running channel, the commit happens at the edge where the counter wraps from period−1 to 0. Bit 2 reads 1 until that edge.
- R8: The start write is at edge E0. The output after edge Ek (k ≥ 1) is set by counter value (k−1) mod period. It is 0 after E0. With polarity 1, the output is high while the counter is below the duty value and low otherwise.
- R9: With polarity 0, the output is low while the counter is below the duty value and high otherwise.
- R10: A committed duty of zero gives a constant low output under either polarity. A duty greater than or equal to the period holds the active level for the whole period.
- R11: A committed period of zero keeps the output low, even after start.
- R12: Channels are independent: register writes and running state of one channel never change another channel's output.
- R13: A control write with bit 0 clear does not stop a running channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all registers and counters |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Register access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (8) | Byte address of the register |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Registered read data |
| pwm_out | output | NUM_CH (6) | One registered waveform output per channel |

## Verification
The waveform logic is swept over every period from 0 to 5, every duty from 0 to 6 and both polarities, with the channel index rotating across all six. This covers normal duty ratios, duty equal to or above the period, zero duty and zero period, and it checks each output cycle against a value computed arithmetically from the edge count since start. A second pattern changes period, duty and polarity on a running channel while a neighbour channel also runs. The output must keep its old shape through staging-only writes and through the rest of the current period, then switch exactly at the wrap. This separates commit-at-boundary from commit-at-once and from commit-without-update. Register readback, unmapped offsets and the pending bit are checked over the bus.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
  // Each channel owns a 32-byte slice of the address space
  localparam int CH_SPAN_LOG2 = 5;

  localparam logic [CH_SPAN_LOG2-1:0] OFS_CTRL = 5'h00;
  localparam logic [CH_SPAN_LOG2-1:0] OFS_PER  = 5'h08;
  localparam logic [CH_SPAN_LOG2-1:0] OFS_DUTY = 5'h0C;

  // Control word bit positions
  localparam int BIT_START = 0;
  localparam int BIT_UPD   = 2;
  localparam int BIT_CONT  = 5;
  localparam int BIT_POL   = 8;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_PER,
    SEL_DUTY
  } reg_sel_e;
endpackage

// File: rtl/pwm_addr_dec.sv
module pwm_addr_dec
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int AW     = 8,
  parameter int CW     = 3
) (
  input  logic [AW-1:0] addr,
  output logic [CW-1:0] ch,
  output reg_sel_e      sel,
  output logic          hit
);
  localparam int FW = AW - CH_SPAN_LOG2;

  logic [FW-1:0]           field;
  logic [CH_SPAN_LOG2-1:0] ofs;

  assign field = addr[AW-1:CH_SPAN_LOG2];
  assign ofs   = addr[CH_SPAN_LOG2-1:0];

  always_comb begin
    case (ofs)
      OFS_CTRL: sel = SEL_CTRL;
      OFS_PER:  sel = SEL_PER;
      OFS_DUTY: sel = SEL_DUTY;
      default:  sel = SEL_NONE;
    endcase
    if (32'(field) >= NUM_CH) sel = SEL_NONE;
  end

  assign hit = (sel != SEL_NONE);
  assign ch  = CW'(field);
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [DW-1:0] per,
  input  logic [DW-1:0] duty,
  input  logic          pol,
  output logic          wrap,
  output logic          pwm_o
);
  logic [DW-1:0] cnt;
  logic          pwm_q;

  // Last cycle of the period; a zero period wraps every cycle
  assign wrap = (per == '0) || (cnt >= per - DW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      pwm_q <= 1'b0;
    end else begin
      if (!run || wrap) cnt <= '0;
      else              cnt <= cnt + DW'(1);
      pwm_q <= run && (per != '0) && (duty != '0) &&
               ((cnt < duty) ? pol : ~pol);
    end
  end

  assign pwm_o = pwm_q;
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_bank_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_ctrl,
  input  logic          wr_per,
  input  logic          wr_duty,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rd_ctrl,
  output logic [DW-1:0] rd_per,
  output logic [DW-1:0] rd_duty,
  output logic          pwm_o,
  output logic          running,
  output logic          pending,
  output logic          per_zero,
  output logic          duty_zero
);
  // Staged values written by software
  logic [DW-1:0] sh_per, sh_duty;
  logic          sh_pol, cont_q;
  // Values the counter is working with
  logic [DW-1:0] act_per, act_duty;
  logic          act_pol;
  logic          run_q, pend_q;
  logic          wrap, commit;

  assign commit = pend_q && (!run_q || wrap);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_per   <= '0;
      sh_duty  <= '0;
      sh_pol   <= 1'b0;
      cont_q   <= 1'b0;
      act_per  <= '0;
      act_duty <= '0;
      act_pol  <= 1'b0;
      run_q    <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      if (wr_per)  sh_per  <= wdata;
      if (wr_duty) sh_duty <= wdata;
      if (commit) begin
        act_per  <= sh_per;
        act_duty <= sh_duty;
        act_pol  <= sh_pol;
        pend_q   <= 1'b0;
      end
      if (wr_ctrl) begin
        sh_pol <= wdata[BIT_POL];
        cont_q <= wdata[BIT_CONT];
        if (wdata[BIT_UPD])   pend_q <= 1'b1;
        if (wdata[BIT_START]) run_q  <= 1'b1;
      end
    end
  end

  always_comb begin
    rd_ctrl            = '0;
    rd_ctrl[BIT_START] = run_q;
    rd_ctrl[BIT_UPD]   = pend_q;
    rd_ctrl[BIT_CONT]  = cont_q;
    rd_ctrl[BIT_POL]   = sh_pol;
  end

  assign rd_per    = sh_per;
  assign rd_duty   = sh_duty;
  assign running   = run_q;
  assign pending   = pend_q;
  assign per_zero  = (act_per == '0);
  assign duty_zero = (act_duty == '0);

  pwm_counter #(.DW(DW)) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .run  (run_q),
    .per  (act_per),
    .duty (act_duty),
    .pol  (act_pol),
    .wrap (wrap),
    .pwm_o(pwm_o)
  );
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int DW     = 32,
  parameter int AW     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic [NUM_CH-1:0] pwm_out
);
  localparam int CW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [CW-1:0] bus_ch;
  reg_sel_e      bus_sel;
  logic          bus_hit;
  logic          wr_go;

  logic [NUM_CH-1:0] ctrl_wr_vec, per_wr_vec, duty_wr_vec;
  logic [NUM_CH-1:0] run_vec, pend_vec, per_zero_vec, duty_zero_vec;
  logic [DW-1:0]     rd_ctrl_a [NUM_CH];
  logic [DW-1:0]     rd_per_a  [NUM_CH];
  logic [DW-1:0]     rd_duty_a [NUM_CH];
  logic [DW-1:0]     rd_pick;
  logic [DW-1:0]     rdata_q;

  pwm_addr_dec #(.NUM_CH(NUM_CH), .AW(AW), .CW(CW)) u_dec (
    .addr(bus_addr),
    .ch  (bus_ch),
    .sel (bus_sel),
    .hit (bus_hit)
  );

  assign wr_go = bus_en && bus_we && bus_hit;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign ctrl_wr_vec[i] = wr_go && (bus_ch == CW'(i)) && (bus_sel == SEL_CTRL);
    assign per_wr_vec[i]  = wr_go && (bus_ch == CW'(i)) && (bus_sel == SEL_PER);
    assign duty_wr_vec[i] = wr_go && (bus_ch == CW'(i)) && (bus_sel == SEL_DUTY);

    pwm_channel #(.DW(DW)) u_chan (
      .clk      (clk),
      .rst      (rst),
      .wr_ctrl  (ctrl_wr_vec[i]),
      .wr_per   (per_wr_vec[i]),
      .wr_duty  (duty_wr_vec[i]),
      .wdata    (bus_wdata),
      .rd_ctrl  (rd_ctrl_a[i]),
      .rd_per   (rd_per_a[i]),
      .rd_duty  (rd_duty_a[i]),
      .pwm_o    (pwm_out[i]),
      .running  (run_vec[i]),
      .pending  (pend_vec[i]),
      .per_zero (per_zero_vec[i]),
      .duty_zero(duty_zero_vec[i])
    );
  end

  always_comb begin
    rd_pick = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (bus_hit && (bus_ch == CW'(i))) begin
        case (bus_sel)
          SEL_CTRL: rd_pick = rd_ctrl_a[i];
          SEL_PER:  rd_pick = rd_per_a[i];
          SEL_DUTY: rd_pick = rd_duty_a[i];
          default:  rd_pick = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                    rdata_q <= '0;
    else if (bus_en && !bus_we) rdata_q <= rd_pick;
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk #(
  parameter int NUM_CH = 6,
  parameter int DW     = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_en,
  input logic              bus_we,
  input logic              bus_hit,
  input logic [DW-1:0]     bus_rdata,
  input logic [NUM_CH-1:0] pwm_out,
  input logic [NUM_CH-1:0] run_vec,
  input logic [NUM_CH-1:0] pend_vec,
  input logic [NUM_CH-1:0] ctrl_wr_vec,
  input logic [NUM_CH-1:0] per_zero_vec,
  input logic [NUM_CH-1:0] duty_zero_vec
);
  AST_UNMAPPED_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    bus_en && !bus_we && !bus_hit |=> bus_rdata == '0); // R3

  for (genvar i = 0; i < NUM_CH; i++) begin : g_a
    AST_IDLE_OUTPUT_LOW: assert property (@(posedge clk) disable iff (rst)
      !run_vec[i] |=> !pwm_out[i]); // R8
    AST_RUN_STICKY: assert property (@(posedge clk) disable iff (rst)
      run_vec[i] |=> run_vec[i]); // R13
    AST_IDLE_COMMIT_NEXT: assert property (@(posedge clk) disable iff (rst)
      pend_vec[i] && !run_vec[i] && !ctrl_wr_vec[i] |=> !pend_vec[i]); // R6
    AST_ZERO_DUTY_LOW: assert property (@(posedge clk) disable iff (rst)
      duty_zero_vec[i] |=> !pwm_out[i]); // R10
    AST_ZERO_PERIOD_LOW: assert property (@(posedge clk) disable iff (rst)
      per_zero_vec[i] |=> !pwm_out[i]); // R11
  end
endmodule

bind pwm_bank pwm_bank_chk #(.NUM_CH(NUM_CH), .DW(DW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .bus_en       (bus_en),
  .bus_we       (bus_we),
  .bus_hit      (bus_hit),
  .bus_rdata    (bus_rdata),
  .pwm_out      (pwm_out),
  .run_vec      (run_vec),
  .pend_vec     (pend_vec),
  .ctrl_wr_vec  (ctrl_wr_vec),
  .per_zero_vec (per_zero_vec),
  .duty_zero_vec(duty_zero_vec)
);

// File: tb/tb_pwm_bank.sv
module tb_pwm_bank;
  localparam int NUM_CH = 6;
  localparam int DW     = 32;
  localparam int AW     = 8;
  localparam logic [DW-1:0] CT_START = 32'h001;
  localparam logic [DW-1:0] CT_UPD   = 32'h004;
  localparam logic [DW-1:0] CT_CONT  = 32'h020;
  localparam logic [DW-1:0] CT_POL   = 32'h100;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bus_en = 1'b0;
  logic              bus_we = 1'b0;
  logic [AW-1:0]     bus_addr = '0;
  logic [DW-1:0]     bus_wdata = '0;
  logic [DW-1:0]     bus_rdata;
  logic [NUM_CH-1:0] pwm_out;

  always #10 clk = ~clk;

  pwm_bank #(.NUM_CH(NUM_CH), .DW(DW), .AW(AW)) dut (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  int checks = 0;
  int errors = 0;
  int ecount = 0;
  bit done = 0;

  always @(posedge clk) ecount <= ecount + 1;

  // Expected-waveform description for the monitored channel
  bit mon_en = 0;
  int mon_ch = 0;
  int s_idx = 0;
  int oP = 0, oD = 0, nP = 1, nD = 0, bnd = 1 << 30;
  bit oPol = 0, nPol = 0;

  function automatic bit wave(int p, int d, bit pol, int c);
    if (p == 0 || d == 0) return 1'b0;
    return (c < d) ? pol : !pol;
  endfunction

  function automatic bit exp_out(int k);
    if (k <= 0) return 1'b0;
    if (k <= bnd) return (oP == 0) ? 1'b0 : wave(oP, oD, oPol, (k - 1) % oP);
    return wave(nP, nD, nPol, (k - bnd - 1) % nP);
  endfunction

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (mon_en && !done)
      chk("R8/R9/R10/R11 waveform", DW'(pwm_out[mon_ch]), DW'(exp_out(ecount - s_idx)));
  end

  task automatic wr(int a, logic [DW-1:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(posedge clk);
    #1;
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(int a, output logic [DW-1:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = AW'(a);
    @(posedge clk);
    #1;
    bus_en = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic do_reset();
    mon_en = 0;
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run_cfg(int ch, int p, int d, bit pol);
    logic [DW-1:0] pw;
    int base;
    base = ch * 32;
    pw = pol ? CT_POL : '0;
    do_reset();
    wr(base + 8, DW'(p));
    wr(base + 12, DW'(d));
    wr(base, CT_CONT | pw | CT_UPD);
    oP = p; oD = d; oPol = pol; bnd = 1 << 30; mon_ch = ch;
    wr(base, CT_CONT | pw | CT_START);
    s_idx = ecount;
    mon_en = 1;
    repeat (2 * p + 4) @(negedge clk);
    #1;
    mon_en = 0;
    chk("R12 other channels idle", DW'(pwm_out & ~(NUM_CH'(1) << ch)), '0);
  endtask

  logic [DW-1:0] v;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk("R1 outputs low", DW'(pwm_out), '0);
    for (int c = 0; c < NUM_CH; c++) begin
      rd(c * 32, v);      chk("R1 ctrl zero", v, '0);
      rd(c * 32 + 8, v);  chk("R1 period zero", v, '0);
      rd(c * 32 + 12, v); chk("R1 duty zero", v, '0);
    end

    // R2: map and staged readback
    wr(8'hA8, 32'hDEADBEEF);
    wr(8'hAC, 32'h12345678);
    rd(8'hA8, v); chk("R2 ch5 period readback", v, 32'hDEADBEEF);
    rd(8'hAC, v); chk("R2 ch5 duty readback", v, 32'h12345678);
    rd(8'h08, v); chk("R2 ch0 period untouched", v, '0);

    // R3: unmapped offsets
    wr(8'h04, 32'hFFFFFFFF);
    rd(8'h04, v); chk("R3 unmapped offset reads zero", v, '0);
    wr(8'h30, 32'hFFFFFFFF);
    rd(8'h28, v); chk("R3 ch1 period unchanged", v, '0);
    rd(8'h20, v); chk("R3 ch1 ctrl unchanged", v, '0);
    wr(8'hC8, 32'h5);
    rd(8'hC8, v); chk("R3 channel index 6 reads zero", v, '0);

    // R6: idle commit clears the pending bit
    do_reset();
    wr(8'h48, 32'd5);
    wr(8'h40, CT_CONT | CT_UPD);
    @(negedge clk);
    rd(8'h40, v); chk("R6 pending cleared on idle channel", v, CT_CONT);

    // R8..R11 sweep across period, duty, polarity and channel
    for (int p = 0; p <= 5; p++)
      for (int d = 0; d <= 6; d++)
        for (int pl = 0; pl <= 1; pl++)
          run_cfg((p * 14 + d * 2 + pl) % NUM_CH, p, d, pl[0]);

    // R5, R7, R12, R13: reconfigure a running channel beside another running one
    do_reset();
    wr(8'h88, 32'd3);
    wr(8'h8C, 32'd2);
    wr(8'h80, CT_CONT | CT_POL | CT_UPD);
    wr(8'h80, CT_CONT | CT_POL | CT_START);
    wr(8'h48, 32'd4);
    wr(8'h4C, 32'd1);
    wr(8'h40, CT_CONT | CT_POL | CT_UPD);
    oP = 4; oD = 1; oPol = 1; nP = 1; nD = 0; nPol = 0; bnd = 1 << 30; mon_ch = 2;
    wr(8'h40, CT_CONT | CT_POL | CT_START);
    s_idx = ecount;
    mon_en = 1;
    rd(8'h40, v); chk("R4 ctrl readback running", v, CT_CONT | CT_POL | CT_START);
    repeat (3) @(negedge clk);
    // R5 staging only; R13 control write with start clear
    wr(8'h48, 32'd3);
    wr(8'h4C, 32'd2);
    wr(8'h40, CT_CONT);
    repeat (6) @(negedge clk);
    rd(8'h48, v); chk("R2 staged period readback", v, 32'd3);
    // R7 update on running channel
    wr(8'h40, CT_CONT | CT_UPD);
    begin
      int k;
      k = ecount - s_idx + 1;
      while ((k - 1) % 4 != 3) k++;
      nP = 3; nD = 2; nPol = 0;
      bnd = k;
    end
    rd(8'h40, v); chk("R7 pending while running", v, CT_CONT | CT_UPD | CT_START);
    repeat (6) @(negedge clk);
    rd(8'h40, v); chk("R7 pending cleared after wrap", v, CT_CONT | CT_START);
    repeat (8) @(negedge clk);
    #1;
    mon_en = 0;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule